// File: doc/BRIEF.md
# Table-driven programmable state machine

This block is a general-purpose sequencing engine. Its behaviour is not fixed in logic. It comes from two loadable tables. The rule table holds up to `N_RULES` entries. Each entry names a source state, a condition code and a destination state. The limit table holds one dwell limit for each of the `N_STATES` states. On every control-cycle strobe the engine latches a vector of condition bits. It then walks the rule table from entry 0 upward and moves to the destination of the first rule whose source equals the active state and whose condition holds. The condition vector is organised as 16-bit words: condition k sits in bit k mod 16 of word k div 16, which is bit k of the flat `cond_i` port.

The active state is shown two ways: as a binary index, and as a one-hot vector laid out in the same 16-bit word order. A dwell counter counts strobes spent in the current state and raises a timeout flag once it passes that state's limit. Three controls take effect on a strobe, in this order of precedence: a machine reset, a forced jump triggered by an edge on `force_go`, and a hold. An optional chaining mode lets several transitions happen inside one strobe. A single pulse on `done` marks the end of each evaluation.

Top module: `tbl_fsm_engine`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first strobe, the engine reports state 0 (`state_onehot` equal to 1), dwell 0, `timeout` low and `done` low. All rules are disabled and all limits are zero.
- R2: `state_onehot` has exactly one bit set, at position `state_idx`. That is bit (i mod 16) of 16-bit word (i div 16).
- R3: A condition code c below 1000 tests condition bit c. A code of 1000 or more tests the inverse of bit c-1000. A rule whose tested index is not below `N_CONDS` never matches.
- R4: Rules are tried in ascending table order, and the first enabled rule whose source equals the active state and whose condition holds is taken. A rule that is disabled, or whose source or destination is not below `N_STATES`, is skipped. If no rule matches, the state is unchanged.
- R5: A strobe with `fsm_reset` high puts the engine in state 0 with dwell 0 and `timeout` low. This overrides the forced jump, hold and every rule.
- R6: A strobe at which `force_go` is high, when it was low at the previous strobe, jumps to `force_state` and clears dwell and `timeout`. No rules are evaluated on that strobe. If `force_state` is not below `N_STATES`, the state, dwell and `timeout` stay unchanged.
- R7: A strobe with `hold` high, and neither a reset nor a forced jump, leaves the state, dwell and `timeout` unchanged, whatever the conditions are.
- R8: An evaluated strobe on which no rule fires increments dwell by one. Dwell saturates at its maximum value instead of wrapping.
- R9: After such a strobe, `timeout` is high exactly when the state's limit is nonzero and dwell is greater than that limit. A strobe on which any rule fires clears both dwell and `timeout`.
- R10: With `chain_en` low, at most one rule fires per strobe. With `chain_en` high, the scan restarts from entry 0 after every firing, until no rule matches or `MAX_CHAIN` rules have fired.
- R11: Every accepted strobe produces exactly one one-cycle `done` pulse, after which the outputs hold the result. A strobe arriving while a scan is in progress is ignored. Outputs do not change between strobes.
- R12: When `cfg_we` is high with `cfg_sel` = 0, the word at `cfg_addr` of the rule table is written, with this layout: bits [7:0] source, [15:8] destination, [30:16] condition code, [31] enable. When `cfg_we` is high with `cfg_sel` = 1, the limit of state `cfg_addr` is written from the low `DWELL_W` bits. Addresses past the table size are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Control-cycle strobe |
| chain_en | input | 1 | Allow several transitions per strobe |
| fsm_reset | input | 1 | Return to state 0 at the strobe |
| force_go | input | 1 | Forced jump, acts on a rising level seen between strobes |
| force_state | input | 8 | Target of the forced jump |
| hold | input | 1 | Freeze state and dwell at the strobe |
| cond_i | input | N_CONDS | Condition bits, 16-bit words packed low word first |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 1 | 0 selects the rule table, 1 selects the limit table |
| cfg_addr | input | 8 | Table entry index |
| cfg_wdata | input | 32 | Table write data |
| state_onehot | output | N_STATES | One-hot active state, 16-bit words packed low word first |
| state_idx | output | $clog2(N_STATES) | Binary active state |
| dwell | output | DWELL_W | Strobes spent in the current state |
| timeout | output | 1 | Dwell has passed the state's limit |
| done | output | 1 | One-cycle pulse marking the end of an evaluation |

## Verification
A wrong rule pointer, a wrong latched condition or a wrong priority choice shows up as a wrong `state_idx` and one-hot word at the `done` pulse of the very strobe where it happens. Because the next strobe's rules are keyed on that state, the error then spreads through every later step. A bad dwell or limit lookup shows in `dwell` or `timeout` at the first strobe without a transition. A broken scan sequencer shows as a missing or doubled `done` pulse, or as state movement between strobes. Comparing every strobe's outputs against an arithmetic model, across sweeps of mixed control and condition patterns, therefore catches a fault within one strobe of its cause.

// File: rtl/tbl_fsm_pkg.sv
package tbl_fsm_pkg;

    localparam int STATE_FIELD_W = 8;
    localparam int CODE_W        = 15;
    localparam int NEG_BASE      = 1000;

    // rule word as stored: enable, condition code, destination, source
    typedef struct packed {
        logic                     en;
        logic [CODE_W-1:0]        code;
        logic [STATE_FIELD_W-1:0] dst;
        logic [STATE_FIELD_W-1:0] src;
    } rule_t;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;

endpackage

// File: rtl/tbl_rule_store.sv
module tbl_rule_store
    import tbl_fsm_pkg::*;
#(
    parameter int N_RULES  = 256,
    parameter int N_STATES = 256,
    parameter int DWELL_W  = 32,
    localparam int RW = $clog2(N_RULES),
    localparam int SW = $clog2(N_STATES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [7:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    input  logic [RW-1:0]      rd_ptr,
    output rule_t              rule_o,
    input  logic [SW-1:0]      lim_sel,
    output logic [DWELL_W-1:0] lim_o
);

    rule_t              rules_q [N_RULES];
    logic [DWELL_W-1:0] lims_q  [N_STATES];

    logic rule_we, lim_we;

    always_comb begin
        rule_we = cfg_we && !cfg_sel && (32'(cfg_addr) < N_RULES);
        lim_we  = cfg_we &&  cfg_sel && (32'(cfg_addr) < N_STATES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_RULES; i++) rules_q[i] <= '0;
        end else if (rule_we) begin
            rules_q[cfg_addr[RW-1:0]] <= cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_STATES; i++) lims_q[i] <= '0;
        end else if (lim_we) begin
            lims_q[cfg_addr[SW-1:0]] <= cfg_wdata[DWELL_W-1:0];
        end
    end

    assign rule_o = rules_q[rd_ptr];
    assign lim_o  = lims_q[lim_sel];

endmodule

// File: rtl/tbl_cond_eval.sv
module tbl_cond_eval
    import tbl_fsm_pkg::*;
#(
    parameter int N_CONDS = 256,
    localparam int CW = $clog2(N_CONDS)
) (
    input  logic [N_CONDS-1:0] cond_i,
    input  logic [CODE_W-1:0]  code,
    output logic               hit
);

    logic              negate;
    logic [CODE_W-1:0] bit_idx;
    logic              in_range;

    always_comb begin
        negate   = (32'(code) >= NEG_BASE);
        bit_idx  = negate ? (code - CODE_W'(NEG_BASE)) : code;
        in_range = (32'(bit_idx) < N_CONDS);
        hit      = in_range && (cond_i[bit_idx[CW-1:0]] ^ negate);
    end

endmodule

// File: rtl/tbl_onehot_dec.sv
module tbl_onehot_dec #(
    parameter int N_STATES = 256,
    localparam int SW = $clog2(N_STATES)
) (
    input  logic [SW-1:0]       idx,
    output logic [N_STATES-1:0] onehot
);

    for (genvar g = 0; g < N_STATES; g++) begin : g_bit
        assign onehot[g] = (idx == SW'(g));
    end

endmodule

// File: rtl/tbl_fsm_engine.sv
module tbl_fsm_engine
    import tbl_fsm_pkg::*;
#(
    parameter int N_STATES  = 256,
    parameter int N_RULES   = 256,
    parameter int N_CONDS   = 256,
    parameter int DWELL_W   = 32,
    parameter int MAX_CHAIN = 256,
    localparam int SW = $clog2(N_STATES),
    localparam int RW = $clog2(N_RULES),
    localparam int MW = $clog2(MAX_CHAIN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                chain_en,
    input  logic                fsm_reset,
    input  logic                force_go,
    input  logic [7:0]          force_state,
    input  logic                hold,
    input  logic [N_CONDS-1:0]  cond_i,
    input  logic                cfg_we,
    input  logic                cfg_sel,
    input  logic [7:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output logic [N_STATES-1:0] state_onehot,
    output logic [SW-1:0]       state_idx,
    output logic [DWELL_W-1:0]  dwell,
    output logic                timeout,
    output logic                done
);

    typedef struct packed {
        phase_e             ph;
        logic [SW-1:0]      st;
        logic [DWELL_W-1:0] dw;
        logic               to;
        logic               done;
        logic               fprev;
        logic               fired;
        logic [RW-1:0]      ptr;
        logic [MW-1:0]      moves;
        logic [N_CONDS-1:0] cq;
    } eng_t;

    eng_t r_q, r_d;

    rule_t              cur_rule;
    logic [DWELL_W-1:0] cur_lim;
    logic               cond_hit;
    logic               busy;

    tbl_rule_store #(
        .N_RULES (N_RULES),
        .N_STATES(N_STATES),
        .DWELL_W (DWELL_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .rd_ptr   (r_q.ptr),
        .rule_o   (cur_rule),
        .lim_sel  (r_q.st),
        .lim_o    (cur_lim)
    );

    tbl_cond_eval #(
        .N_CONDS(N_CONDS)
    ) u_cond (
        .cond_i(r_q.cq),
        .code  (cur_rule.code),
        .hit   (cond_hit)
    );

    tbl_onehot_dec #(
        .N_STATES(N_STATES)
    ) u_dec (
        .idx   (r_q.st),
        .onehot(state_onehot)
    );

    logic               rule_match;
    logic               finish;
    logic               fired_now;
    logic [MW-1:0]      moves_inc;
    logic [DWELL_W-1:0] dw_inc;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        finish    = 1'b0;
        fired_now = r_q.fired;
        moves_inc = r_q.moves + 1'b1;
        dw_inc    = (r_q.dw == {DWELL_W{1'b1}}) ? r_q.dw : r_q.dw + 1'b1;

        rule_match = cur_rule.en
                  && (32'(cur_rule.src) < N_STATES)
                  && (32'(cur_rule.dst) < N_STATES)
                  && (cur_rule.src[SW-1:0] == r_q.st)
                  && cond_hit;

        unique case (r_q.ph)
            PH_IDLE: begin
                if (tick) begin
                    r_d.fprev = force_go;
                    r_d.done  = 1'b1;
                    if (fsm_reset) begin
                        r_d.st = '0;
                        r_d.dw = '0;
                        r_d.to = 1'b0;
                    end else if (force_go && !r_q.fprev) begin
                        if (32'(force_state) < N_STATES) begin
                            r_d.st = force_state[SW-1:0];
                            r_d.dw = '0;
                            r_d.to = 1'b0;
                        end
                    end else if (hold) begin
                        r_d.st = r_q.st;
                    end else begin
                        r_d.done  = 1'b0;
                        r_d.ph    = PH_SCAN;
                        r_d.ptr   = '0;
                        r_d.moves = '0;
                        r_d.fired = 1'b0;
                        r_d.cq    = cond_i;
                    end
                end
            end
            PH_SCAN: begin
                if (rule_match) begin
                    r_d.st    = cur_rule.dst[SW-1:0];
                    r_d.fired = 1'b1;
                    fired_now = 1'b1;
                    r_d.moves = moves_inc;
                    if (chain_en && (32'(moves_inc) < MAX_CHAIN)) begin
                        r_d.ptr = '0;
                    end else begin
                        finish = 1'b1;
                    end
                end else if (r_q.ptr == RW'(N_RULES - 1)) begin
                    finish = 1'b1;
                end else begin
                    r_d.ptr = r_q.ptr + 1'b1;
                end

                if (finish) begin
                    r_d.ph   = PH_IDLE;
                    r_d.done = 1'b1;
                    if (fired_now) begin
                        r_d.dw = '0;
                        r_d.to = 1'b0;
                    end else begin
                        r_d.dw = dw_inc;
                        r_d.to = (cur_lim != '0) && (dw_inc > cur_lim);
                    end
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.ph == PH_SCAN);
    assign state_idx = r_q.st;
    assign dwell     = r_q.dw;
    assign timeout   = r_q.to;
    assign done      = r_q.done;

endmodule

// File: rtl/tbl_fsm_engine_chk.sv
module tbl_fsm_engine_chk #(
    parameter int N_STATES = 256,
    parameter int DWELL_W  = 32,
    localparam int SW = $clog2(N_STATES)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                fsm_reset,
    input logic                hold,
    input logic                force_go,
    input logic                busy,
    input logic [N_STATES-1:0] state_onehot,
    input logic [SW-1:0]       state_idx,
    input logic [DWELL_W-1:0]  dwell,
    input logic                timeout,
    input logic                done
);

    // R2
    onehot_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_onehot) && state_onehot[state_idx]);

    // R5
    fsm_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !busy && fsm_reset) |=> (state_idx == '0 && dwell == '0 && !timeout && done));

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !busy && !fsm_reset && hold && !force_go)
            |=> ($stable(state_idx) && $stable(dwell) && $stable(timeout)));

    // R11
    quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tick) |=> ($stable(state_idx) && $stable(dwell) && !done));

    // R11
    no_done_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R9
    timeout_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (dwell != '0));

    // R8
    dwell_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dwell == {DWELL_W{1'b1}}) |=> (dwell == {DWELL_W{1'b1}} || dwell == '0));

endmodule

bind tbl_fsm_engine tbl_fsm_engine_chk #(
    .N_STATES(N_STATES),
    .DWELL_W (DWELL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .fsm_reset   (fsm_reset),
    .hold        (hold),
    .force_go    (force_go),
    .busy        (busy),
    .state_onehot(state_onehot),
    .state_idx   (state_idx),
    .dwell       (dwell),
    .timeout     (timeout),
    .done        (done)
);

// File: tb/tbl_fsm_engine_test.sv
`timescale 1ns/1ps
module tbl_fsm_engine_test;

    localparam int NS = 32;
    localparam int NR = 16;
    localparam int NC = 32;
    localparam int DW = 4;
    localparam int MC = 8;
    localparam int SW = $clog2(NS);
    localparam int DMAX = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0, chain_en = 1'b0, fsm_reset = 1'b0;
    logic          force_go = 1'b0, hold = 1'b0;
    logic [7:0]    force_state = '0;
    logic [NC-1:0] cond_i = '0;
    logic          cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [NS-1:0] state_onehot;
    logic [SW-1:0] state_idx;
    logic [DW-1:0] dwell;
    logic          timeout, done;

    always #2.5 clk = ~clk;

    tbl_fsm_engine #(
        .N_STATES(NS), .N_RULES(NR), .N_CONDS(NC), .DWELL_W(DW), .MAX_CHAIN(MC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chain_en(chain_en),
        .fsm_reset(fsm_reset), .force_go(force_go), .force_state(force_state),
        .hold(hold), .cond_i(cond_i), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .state_onehot(state_onehot),
        .state_idx(state_idx), .dwell(dwell), .timeout(timeout), .done(done)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_rule [NR];
    int          m_lim  [NS];
    int          m_st, m_dw;
    logic        m_to, m_fprev;

    task automatic chk(string tag, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int en, int code, int dst, int src);
        return {en[0], code[14:0], dst[7:0], src[7:0]};
    endfunction

    function automatic bit rule_hits(logic [31:0] w);
        int code, idx, src, dst;
        bit neg;
        code = int'(w[30:16]);
        dst  = int'(w[15:8]);
        src  = int'(w[7:0]);
        neg  = code >= 1000;
        idx  = neg ? code - 1000 : code;
        if (!w[31] || src >= NS || dst >= NS || src != m_st || idx >= NC) return 0;
        return cond_i[idx] ^ neg;
    endfunction

    function automatic void model_tick();
        bit fired, found;
        int n;
        logic fp;
        fp = m_fprev;
        m_fprev = force_go;
        if (fsm_reset) begin
            m_st = 0; m_dw = 0; m_to = 0;
        end else if (force_go && !fp) begin
            if (int'(force_state) < NS) begin
                m_st = int'(force_state); m_dw = 0; m_to = 0;
            end
        end else if (!hold) begin
            fired = 0;
            n = 0;
            while (1) begin
                found = 0;
                for (int r = 0; r < NR; r++) begin
                    if (rule_hits(m_rule[r])) begin
                        m_st  = int'(m_rule[r][15:8]);
                        found = 1;
                        break;
                    end
                end
                if (!found) break;
                fired = 1;
                n++;
                if (!chain_en || n >= MC) break;
            end
            if (fired) begin
                m_dw = 0; m_to = 0;
            end else begin
                if (m_dw < DMAX) m_dw++;
                m_to = (m_lim[m_st] != 0) && (m_dw > m_lim[m_st]);
            end
        end
    endfunction

    task automatic compare_all(string tag);
        chk(tag, "state_idx", longint'(state_idx), longint'(m_st));
        chk(tag, "state_onehot", longint'(state_onehot), longint'(64'd1 << m_st));
        chk(tag, "dwell", longint'(dwell), longint'(m_dw));
        chk(tag, "timeout", longint'(timeout), longint'(m_to));
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic do_tick(string tag);
        @(negedge clk);
        tick = 1'b1;
        model_tick();
        @(negedge clk);
        tick = 1'b0;
        wait_done();
        compare_all(tag);
    endtask

    task automatic wr(bit sel, int addr, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr[7:0]; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!sel && addr < NR) m_rule[addr] = data;
        if (sel && addr < NS) m_lim[addr] = int'(data[DW-1:0]);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog: got 0 expected 1 (run did not end)");
        summary();
        $finish;
    end

    initial begin
        int pulses;
        logic [31:0] x;
        for (int i = 0; i < NR; i++) m_rule[i] = '0;
        for (int i = 0; i < NS; i++) m_lim[i] = 0;
        m_st = 0; m_dw = 0; m_to = 0; m_fprev = 0;

        repeat (4) @(negedge clk);
        // R1: state right after reset
        chk("R1", "state_idx", longint'(state_idx), 0);
        chk("R1", "state_onehot", longint'(state_onehot), 1);
        chk("R1", "dwell", longint'(dwell), 0);
        chk("R1", "timeout", longint'(timeout), 0);
        chk("R1", "done", longint'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "done idle", longint'(done), 0);
        chk("R1", "state_idx idle", longint'(state_idx), 0);

        // R1/R12: empty table, no rule fires
        cond_i = '1;
        do_tick("R1 empty table");

        // R12: limits, layout of the limit table
        for (int s = 0; s < NS; s++) wr(1'b1, s, 32'(s % 4));

        // R3: negated condition 1005 tests !bit5
        wr(1'b0, 0, mk(1, 1005, 3, 0));
        cond_i = 32'h20;
        do_tick("R3 negated false");
        chk("R3", "stay at 0", longint'(state_idx), 0);
        cond_i = 32'h0;
        do_tick("R3 negated true");
        chk("R3", "moved to 3", longint'(state_idx), 3);

        // R4: first match wins
        wr(1'b0, 1, mk(1, 2, 7, 3));
        wr(1'b0, 2, mk(1, 2, 9, 3));
        cond_i = 32'h4;
        do_tick("R4 first match");
        chk("R4", "took rule 1", longint'(state_idx), 7);

        // R4/R3: disabled, bad destination, bad condition index all skipped
        wr(1'b0, 3, mk(0, 0, 1, 7));
        wr(1'b0, 4, mk(1, 0, 40, 7));
        wr(1'b0, 5, mk(1, 40, 1, 7));
        cond_i = '1;
        do_tick("R4 skipped rules");
        chk("R4", "stay at 7", longint'(state_idx), 7);

        // R8/R9: dwell counts, timeout once past limit 3
        for (int k = 0; k < 3; k++) do_tick("R9 dwell vs limit");
        chk("R9", "timeout set", longint'(timeout), 1);
        for (int k = 0; k < 14; k++) do_tick("R8 saturation");
        chk("R8", "saturated dwell", longint'(dwell), DMAX);

        // R7: hold freezes despite a matching rule
        wr(1'b0, 6, mk(1, 0, 10, 7));
        hold = 1'b1;
        do_tick("R7 hold");
        hold = 1'b0;
        do_tick("R9 clear on move");
        chk("R9", "timeout cleared", longint'(timeout), 0);

        // R10: single step then chained steps
        wr(1'b0, 7, mk(1, 0, 11, 10));
        wr(1'b0, 8, mk(1, 0, 12, 11));
        do_tick("R10 single step");
        force_go = 1'b1; force_state = 8'd10;
        do_tick("R6 forced jump");
        chain_en = 1'b1;
        do_tick("R10 chain and R6 level no jump");
        chk("R10", "chained to 12", longint'(state_idx), 12);

        // R10: chain bound on a three-state loop
        wr(1'b0, 9,  mk(1, 0, 21, 20));
        wr(1'b0, 10, mk(1, 0, 22, 21));
        wr(1'b0, 11, mk(1, 0, 20, 22));
        force_go = 1'b0;
        do_tick("R6 release");
        force_go = 1'b1; force_state = 8'd20;
        do_tick("R6 edge to 20");
        force_go = 1'b0;
        do_tick("R10 chain bound");
        chk("R10", "stopped after 8", longint'(state_idx), 22);

        // R6: out-of-range target ignored
        force_go = 1'b1; force_state = 8'd35;
        do_tick("R6 invalid target");
        force_go = 1'b0;
        do_tick("R6 release again");

        // R5: reset beats force and rules
        force_go = 1'b1; force_state = 8'd9; fsm_reset = 1'b1;
        do_tick("R5 reset priority");
        fsm_reset = 1'b0; force_go = 1'b0;
        chk("R5", "state zero", longint'(state_idx), 0);

        // R11: strobe during a scan is dropped; one done per accepted strobe
        chain_en = 1'b0;
        cond_i = '1;
        @(negedge clk);
        tick = 1'b1;
        model_tick();
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        wait_done();
        compare_all("R11 busy strobe");
        pulses = 0;
        @(negedge clk);
        for (int c = 0; c < 40; c++) begin
            if (done) pulses++;
            @(negedge clk);
        end
        chk("R11", "extra done pulses", longint'(pulses), 0);

        // R4/R10 sweep with mixed controls against the model
        for (int r = 0; r < NR; r++) begin
            int src, dst, code;
            src  = (r * 3) % 8;
            dst  = (r * 5 + 1) % 8;
            code = (r % 3 == 0) ? 1000 + (r * 7) % 32 : (r * 11) % 32;
            if (r == 14) src = 40;
            if (r == 15) code = 1040;
            wr(1'b0, r, mk((r != 13) ? 1 : 0, code, dst, src));
        end
        fsm_reset = 1'b1;
        do_tick("R5 sweep start");
        fsm_reset = 1'b0;
        x = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            cond_i      = x ^ (x >> 13);
            hold        = (i % 11 == 5);
            fsm_reset   = (i % 37 == 36);
            force_go    = (i % 13 == 7) || (i % 13 == 8);
            force_state = 8'((i * 5) % 40);
            chain_en    = (i >= 200);
            do_tick("R4/R10 sweep");
        end

        summary();
        $finish;
    end

endmodule